// File: doc/BRIEF.md
# Timer Compare Channel

This block is one compare channel placed beside a 16-bit timer counter. On every cycle in which the timer advances, it checks the counter value against its own 16-bit compare register. A hit updates an internal waveform bit and raises a sticky match flag. A 2-bit action field chooses what a hit does to the waveform bit: hold it, toggle it, clear it or set it.

The compare register is written one byte at a time. The high byte goes into a staging register first. The full 16-bit value is loaded in the cycle that the low byte is written. A software write to the counter stops the compare on the next timer tick, so firmware can preload the counter to the compare value without causing an event. A force strobe changes the waveform bit exactly as a hit would, but it leaves the flag and the counter alone. The action field has no buffering, so a new value is used on the very next event.

The asynchronous active-low reset is released through a two-stage synchronizer. The channel therefore starts working on the third clock edge after `rst_n` rises.

Top module: `tmr_cmp_channel`

## Requirements
- R1: While reset is held, and right after it, the waveform bit and the match flag are both 0.
- R2: A write with `cmp_hi_wr` stores `wr_data` in a staging byte and does not change the compare value. A write with `cmp_lo_wr` loads the compare value with the staging byte as bits 15:8 and `wr_data` as bits 7:0. A counter value that matches only the low byte gives no hit.
- R3: A cycle with `tmr_tick` high, `cnt_val` equal to the compare value and no block pending is a hit. After that clock edge, `match_flag_o` is 1.
- R4: The match flag stays set until a cycle with `flag_clr` high clears it. If a hit and `flag_clr` fall in the same cycle, the flag ends up set.
- R5: A `cnt_wr` pulse blocks the first tick that follows it, however many idle cycles come between. On that tick an equal compare gives no flag and no change to the waveform bit.
- R6: The block covers only one tick. The next tick after the blocked one compares as normal.
- R7: On a hit, `act_mode` acts on the waveform bit as follows: 2'b00 holds it, 2'b01 toggles it, 2'b10 clears it to 0, 2'b11 sets it to 1.
- R8: When `pwm_sel` is 0, a `frc_stb` pulse applies the `act_mode` action to the waveform bit and leaves the match flag unchanged.
- R9: When `pwm_sel` is 1, a `frc_stb` pulse has no effect on the waveform bit.
- R10: A change to `act_mode` applies to an event in the same cycle. There is no delay stage.
- R11: Changing `pwm_sel` does not change the waveform bit.
- R12: A counter value equal to the compare value gives no hit in a cycle where `tmr_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_tick | input | 1 | Timer clock enable; high on cycles in which the counter advances |
| cnt_val | input | 16 | Current counter value |
| cnt_wr | input | 1 | Strobe: software wrote the counter this cycle |
| frc_stb | input | 1 | Force strobe, one cycle long |
| pwm_sel | input | 1 | 1 when a PWM waveform mode is selected |
| act_mode | input | 2 | Action taken on an event: hold, toggle, clear or set |
| cmp_hi_wr | input | 1 | Write strobe for the high-byte staging register |
| cmp_lo_wr | input | 1 | Write strobe for the low byte; loads the whole compare value |
| wr_data | input | 8 | Write data byte |
| flag_clr | input | 1 | Writing 1 clears the match flag |
| wave_o | output | 1 | Internal waveform bit |
| match_flag_o | output | 1 | Sticky match flag |

## Verification
Each event is registered once. A hit or force in a cycle shows on `wave_o` and `match_flag_o` right after the next rising edge. A byte write changes the compare value after the same edge, so it applies to ticks from the following cycle on. A counter write keeps its block until the next tick, however long the wait. The bench drives inputs on falling edges and runs a behavioural model on each rising edge. It compares both outputs with the model 3 ns after every rising edge. The directed checks read the outputs at the falling edge after the stimulus cycle, and the reset model allows for the two-cycle synchronizer delay.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_mode_e;
endpackage

// File: rtl/tmr_cmp_rst_sync.sv
module tmr_cmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_cmp_load.sv
module tmr_cmp_load #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_q
);
  localparam int LO_W = CNT_W - BYTE_W;

  logic [BYTE_W-1:0] stage_q, stage_d;
  logic [CNT_W-1:0]  cmp_d;

  always_comb begin
    stage_d = hi_wr ? wdata : stage_q;
    cmp_d   = cmp_q;
    if (lo_wr) cmp_d = {stage_q, wdata[LO_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      cmp_q   <= '0;
    end else begin
      stage_q <= stage_d;
      cmp_q   <= cmp_d;
    end
  end

  // R2: low-byte write merges staged high byte in the same cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> cmp_q == {$past(stage_q), $past(wdata[LO_W-1:0])});
  // R2: high-byte write alone leaves the compare value untouched
  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !lo_wr) |=> $stable(cmp_q));
endmodule

// File: rtl/tmr_cmp_detect.sv
module tmr_cmp_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             hit
);
  logic block_q, block_d;

  always_comb begin
    block_d = block_q;
    if (tick)   block_d = 1'b0;
    if (cnt_wr) block_d = 1'b1;
    hit = tick && !block_q && (cnt == cmp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) block_q <= 1'b0;
    else        block_q <= block_d;
  end

  // R5: a counter write last cycle suppresses any hit now
  p_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_wr) |-> !hit);
  // R12: no hit without a timer tick
  p_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !hit);
endmodule

// File: rtl/tmr_cmp_wave.sv
module tmr_cmp_wave
  import tmr_cmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  logic      force_stb,
  input  logic      pwm_sel,
  input  act_mode_e mode,
  input  logic      flag_clr,
  output logic      wave_q,
  output logic      flag_q
);
  logic evt;
  logic wave_d, flag_d;

  always_comb begin
    evt    = hit || (force_stb && !pwm_sel);
    wave_d = wave_q;
    if (evt) begin
      unique case (mode)
        ACT_HOLD:   wave_d = wave_q;
        ACT_TOGGLE: wave_d = !wave_q;
        ACT_CLEAR:  wave_d = 1'b0;
        ACT_SET:    wave_d = 1'b1;
      endcase
    end
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (hit)      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      wave_q <= wave_d;
      flag_q <= flag_d;
    end
  end

  // R3, R4: a hit always leaves the flag set, even against a clear
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R4: clear without a hit drops the flag
  p_flag_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit) |=> !flag_q);
  // R8: forcing never raises the flag
  p_force_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !hit && !flag_q) |=> !flag_q);
  // R9: force ignored under PWM selection
  p_pwm_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_sel && !hit) |=> $stable(wave_q));
  // R7: hold action keeps the bit
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ACT_HOLD) |=> $stable(wave_q));
endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel
  import tmr_cmp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_wr,
  input  logic              frc_stb,
  input  logic              pwm_sel,
  input  logic [1:0]        act_mode,
  input  logic              cmp_hi_wr,
  input  logic              cmp_lo_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic              wave_o,
  output logic              match_flag_o
);
  logic             rst_core_n;
  logic [CNT_W-1:0] cmp_val;
  logic             hit;

  tmr_cmp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  tmr_cmp_load #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_load (
    .clk(clk), .rst_n(rst_core_n), .hi_wr(cmp_hi_wr), .lo_wr(cmp_lo_wr),
    .wdata(wr_data), .cmp_q(cmp_val)
  );

  tmr_cmp_detect #(.CNT_W(CNT_W)) u_det (
    .clk(clk), .rst_n(rst_core_n), .tick(tmr_tick), .cnt_wr(cnt_wr),
    .cnt(cnt_val), .cmp(cmp_val), .hit(hit)
  );

  tmr_cmp_wave u_wave (
    .clk(clk), .rst_n(rst_core_n), .hit(hit), .force_stb(frc_stb),
    .pwm_sel(pwm_sel), .mode(act_mode_e'(act_mode)), .flag_clr(flag_clr),
    .wave_q(wave_o), .flag_q(match_flag_o)
  );

  // R1: outputs cleared while the core is held in reset
  p_rst_r1: assert property (@(posedge clk)
    !rst_core_n |-> (!wave_o && !match_flag_o));
  // R11: mode selection change alone leaves the waveform bit alone
  p_pwm_keep_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!hit && !frc_stb) |=> $stable(wave_o));
endmodule

// File: tb/tmr_cmp_channel_test.sv
module tmr_cmp_channel_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b1;
  logic tick = 0, cnt_wr = 0, frc = 0, pwm = 0, hi_wr = 0, lo_wr = 0, fclr = 0;
  logic [1:0]  mode = 2'b11;
  logic [15:0] cnt = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic wave, flag;

  int total = 0, bad = 0;
  string cur = "R1";

  int m_stage = 0, m_cmp = 0, m_blk = 0, m_wave = 0, m_flag = 0, m_rc = 0;

  tmr_cmp_channel uut (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tick), .cnt_val(cnt), .cnt_wr(cnt_wr),
    .frc_stb(frc), .pwm_sel(pwm), .act_mode(mode), .cmp_hi_wr(hi_wr),
    .cmp_lo_wr(lo_wr), .wr_data(wdata), .flag_clr(fclr),
    .wave_o(wave), .match_flag_o(flag)
  );

  task automatic chk(string req, string what, logic act, int exp);
    total++;
    if (act !== exp[0]) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference, evaluated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_cmp = 0; m_blk = 0; m_wave = 0; m_flag = 0; m_rc = 0;
    end else if (m_rc < 2) begin
      m_rc++;
    end else begin
      bit h, ev;
      h  = (tick === 1'b1) && (m_blk == 0) && (int'(cnt) == m_cmp);
      ev = h || (frc && !pwm);
      if (ev) begin
        if (mode == 2'd1) m_wave = 1 - m_wave;
        else if (mode == 2'd2) m_wave = 0;
        else if (mode == 2'd3) m_wave = 1;
      end
      if (lo_wr) m_cmp = m_stage * 256 + int'(wdata);
      if (hi_wr) m_stage = int'(wdata);
      if (cnt_wr) m_blk = 1; else if (tick) m_blk = 0;
      if (h) m_flag = 1; else if (fclr) m_flag = 0;
    end
  end

  always @(posedge clk) begin
    #3;
    chk(cur, "model wave", wave, m_wave);
    chk(cur, "model flag", flag, m_flag);
  end

  task automatic nxt();
    @(negedge clk);
    tick = 0; cnt_wr = 0; frc = 0; hi_wr = 0; lo_wr = 0; fclr = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    #30 rst_n = 1'b1;
    repeat (4) nxt();
    cur = "R1"; chk("R1", "wave", wave, 0); chk("R1", "flag", flag, 0);

    cur = "R2";
    hi_wr = 1; wdata = 8'h12; nxt();
    lo_wr = 1; wdata = 8'h34; nxt();
    tick = 1; cnt = 16'h0034; nxt();
    chk("R2", "low-only flag", flag, 0);

    cur = "R12";
    cnt = 16'h1234; nxt(); nxt();
    chk("R12", "no-tick flag", flag, 0);

    cur = "R3";
    tick = 1; nxt();
    chk("R3", "flag", flag, 1); chk("R7", "set wave", wave, 1);

    cur = "R4";
    nxt(); chk("R4", "sticky flag", flag, 1);
    fclr = 1; nxt(); chk("R4", "cleared flag", flag, 0);
    mode = 2'b10; fclr = 1; tick = 1; nxt();
    chk("R4", "set beats clear", flag, 1); chk("R7", "clear wave", wave, 0);

    cur = "R7";
    fclr = 1; mode = 2'b01; tick = 1; nxt(); chk("R7", "toggle up", wave, 1);
    tick = 1; nxt(); chk("R7", "toggle down", wave, 0);
    tick = 1; nxt(); chk("R7", "toggle up again", wave, 1);
    mode = 2'b00; tick = 1; nxt(); chk("R7", "hold", wave, 1);

    cur = "R10";
    mode = 2'b10; tick = 1; nxt(); chk("R10", "same-cycle mode", wave, 0);
    fclr = 1; nxt();

    cur = "R5";
    mode = 2'b11; cnt_wr = 1; nxt(); nxt(); nxt(); nxt();
    tick = 1; nxt();
    chk("R5", "blocked flag", flag, 0); chk("R5", "blocked wave", wave, 0);
    cur = "R6";
    tick = 1; nxt();
    chk("R6", "next tick flag", flag, 1); chk("R6", "next tick wave", wave, 1);
    fclr = 1; nxt();

    cur = "R8";
    mode = 2'b10; frc = 1; nxt();
    chk("R8", "force clear wave", wave, 0); chk("R8", "force flag", flag, 0);
    mode = 2'b01; frc = 1; nxt();
    chk("R8", "force toggle wave", wave, 1); chk("R8", "force flag 2", flag, 0);

    cur = "R9";
    pwm = 1; mode = 2'b10; frc = 1; nxt();
    chk("R9", "pwm force wave", wave, 1);

    cur = "R11";
    pwm = 0; nxt(); chk("R11", "pwm off wave", wave, 1);
    pwm = 1; nxt(); chk("R11", "pwm on wave", wave, 1);
    pwm = 0;

    cur = "R2";
    mode = 2'b01; hi_wr = 1; wdata = 8'hAB; nxt();
    tick = 1; cnt = 16'h1234; nxt();
    chk("R2", "staged byte not live", flag, 1);
    fclr = 1; lo_wr = 1; wdata = 8'hCD; nxt();
    tick = 1; cnt = 16'h1234; nxt();
    chk("R2", "old value gone", flag, 0);
    tick = 1; cnt = 16'hABCD; nxt();
    chk("R2", "new value hit", flag, 1);
    nxt(); nxt();
    finish_run();
  end
endmodule